// File: doc/BRIEF.md
# Tag-Waiting Reservation Station

This block sits between instruction rename and the execution units. It holds decoded instructions that still lack at least one source operand. Each held instruction carries an opcode and the tag of the temporary register that will receive its result. For each of its two sources it carries either a value or the tag of the producer it is waiting on, plus a ready flag. Completed results are broadcast with their temporary-register tag and a presence flag. Every held entry compares its pending source tags against the broadcast, and it copies the value only while the presence flag is high.

Once both sources of an entry are present, the entry becomes a candidate for the issue port, which uses a valid/ready handshake. Among several candidates the one dispatched earliest wins, and one instruction leaves per cycle. An instruction that arrives with both operands already available, or made available by the broadcast in that same cycle, is sent straight to the issue port and never occupies an entry. This happens only when no held entry is competing for the port and the port can take it. When every entry is full and the instruction cannot go straight through, the dispatch port stalls.

Top module: `tagwait_station`

## Requirements
- R1: A synchronous active-high reset empties every entry; after reset, with no dispatch, `issueValid` is 0 and `dispReady` is 1.
- R2: A dispatch whose two sources are both available, while no held entry is ready and `issueReady` is 1, appears on the issue outputs in the same cycle, is accepted even when all entries are occupied, and leaves no entry behind.
- R3: A dispatched instruction with at least one source not ready is held and does not raise `issueValid`.
- R4: A held source takes a broadcast only when `bcastValid` (the presence flag) is 1 and `bcastTag` equals its waiting tag; a broadcast with another tag, or with `bcastValid` at 0, leaves it waiting.
- R5: An entry whose last missing source is captured at a clock edge is offered on the issue port in the cycle that follows, carrying the captured values.
- R6: A broadcast in the same cycle as a dispatch satisfies any dispatched source waiting on that tag: the value goes into the new entry, or it lets the instruction pass straight to issue.
- R7: When several held entries are ready, they issue in dispatch order, oldest first, one per cycle.
- R8: When all entries are occupied and the dispatch cannot go straight to issue, `dispReady` is 0.
- R9: An entry that issues is freed at that clock edge, and its slot can accept a new dispatch in the next cycle.
- R10: A ready held entry has priority on the issue port over an all-ready dispatch; that dispatch is then stored and issues later.
- R11: While `issueReady` is 0, ready entries stay held, `issueValid` stays 1 and nothing is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| dispValid | input | 1 | Dispatch request |
| dispReady | output | 1 | Dispatch accepted this cycle |
| dispOp | input | OP_W | Opcode of the dispatched instruction |
| dispDstTag | input | TAG_W | Temporary register that receives the result |
| dispSrcARdy | input | 1 | Source A value is present |
| dispSrcATag | input | TAG_W | Producer tag of source A when not present |
| dispSrcAVal | input | DATA_W | Source A value when present |
| dispSrcBRdy | input | 1 | Source B value is present |
| dispSrcBTag | input | TAG_W | Producer tag of source B when not present |
| dispSrcBVal | input | DATA_W | Source B value when present |
| bcastValid | input | 1 | Presence flag of the broadcast result |
| bcastTag | input | TAG_W | Temporary register written by the broadcast |
| bcastVal | input | DATA_W | Broadcast result value |
| issueValid | output | 1 | An instruction is offered for execution |
| issueReady | input | 1 | Execution side accepts the offered instruction |
| issueOp | output | OP_W | Opcode of the issued instruction |
| issueDstTag | output | TAG_W | Destination temporary-register tag |
| issueSrcA | output | DATA_W | Source A operand |
| issueSrcB | output | DATA_W | Source B operand |

## Verification
On every cycle the assertions check several rules. At most one entry is granted the port. A granted entry is valid with both sources present, and a waiting entry is never granted. An issued slot is cleared at the next edge. A write lands only in an empty slot, and a full station with the port blocked refuses dispatch. Other behaviour can only be shown by the bench's scenarios, because it depends on values travelling end to end. These are capture by matching tag and presence only, the same-cycle capture on insertion, oldest-first order among entries that became ready out of order, held entries taking priority over a direct dispatch, and the payload that leaves through the port.

// File: rtl/tagwait_pkg.sv
package tagwait_pkg;
  parameter int RS_ENTRIES = 8;
  parameter int TAG_W      = 5;
  parameter int DATA_W     = 32;
  parameter int OP_W       = 6;
  localparam int IDX_W     = (RS_ENTRIES > 1) ? $clog2(RS_ENTRIES) : 1;

  typedef struct packed {
    logic              rdy;
    logic [TAG_W-1:0]  tag;
    logic [DATA_W-1:0] val;
  } srcField_t;

  typedef struct packed {
    logic [OP_W-1:0]  op;
    logic [TAG_W-1:0] dst;
    srcField_t        a;
    srcField_t        b;
  } rsEntry_t;

  typedef struct packed {
    logic             writeEn;
    logic [IDX_W-1:0] writeIdx;
    logic             issueBuf;
    logic [IDX_W-1:0] issueIdx;
  } ctlStrobe_t;
endpackage

// File: rtl/tagwait_dp.sv
module tagwait_dp
  import tagwait_pkg::*;
(
  input  logic                  clk,
  input  ctlStrobe_t            strobe,
  input  logic [OP_W-1:0]       dispOp,
  input  logic [TAG_W-1:0]      dispDstTag,
  input  logic                  dispSrcARdy,
  input  logic [TAG_W-1:0]      dispSrcATag,
  input  logic [DATA_W-1:0]     dispSrcAVal,
  input  logic                  dispSrcBRdy,
  input  logic [TAG_W-1:0]      dispSrcBTag,
  input  logic [DATA_W-1:0]     dispSrcBVal,
  input  logic                  bcastValid,
  input  logic [TAG_W-1:0]      bcastTag,
  input  logic [DATA_W-1:0]     bcastVal,
  output logic [RS_ENTRIES-1:0] entryRdy,
  output logic                  dispOperandsOk,
  output logic [OP_W-1:0]       issueOp,
  output logic [TAG_W-1:0]      issueDstTag,
  output logic [DATA_W-1:0]     issueSrcA,
  output logic [DATA_W-1:0]     issueSrcB
);

  // A dispatched source is satisfied by its own value or by a same-cycle broadcast.
  function automatic srcField_t mergeSrc(input logic rdy, input logic [TAG_W-1:0] tag,
                                         input logic [DATA_W-1:0] val);
    srcField_t s;
    s.tag = tag;
    if (rdy) begin
      s.rdy = 1'b1;
      s.val = val;
    end else if (bcastValid && (bcastTag == tag)) begin
      s.rdy = 1'b1;
      s.val = bcastVal;
    end else begin
      s.rdy = 1'b0;
      s.val = val;
    end
    return s;
  endfunction

  rsEntry_t incoming;
  rsEntry_t view [RS_ENTRIES];

  always_comb begin
    incoming.op  = dispOp;
    incoming.dst = dispDstTag;
    incoming.a   = mergeSrc(dispSrcARdy, dispSrcATag, dispSrcAVal);
    incoming.b   = mergeSrc(dispSrcBRdy, dispSrcBTag, dispSrcBVal);
  end

  assign dispOperandsOk = incoming.a.rdy & incoming.b.rdy;

  for (genvar gi = 0; gi < RS_ENTRIES; gi++) begin : g_slot
    rsEntry_t slot;
    logic     hitA;
    logic     hitB;

    assign hitA = bcastValid && !slot.a.rdy && (slot.a.tag == bcastTag);
    assign hitB = bcastValid && !slot.b.rdy && (slot.b.tag == bcastTag);

    always_ff @(posedge clk) begin
      if (strobe.writeEn && (strobe.writeIdx == IDX_W'(gi))) begin
        slot <= incoming;
      end else begin
        if (hitA) begin
          slot.a.rdy <= 1'b1;
          slot.a.val <= bcastVal;
        end
        if (hitB) begin
          slot.b.rdy <= 1'b1;
          slot.b.val <= bcastVal;
        end
      end
    end

    assign view[gi]     = slot;
    assign entryRdy[gi] = slot.a.rdy & slot.b.rdy;
  end

  rsEntry_t outSel;
  always_comb begin
    outSel = strobe.issueBuf ? view[strobe.issueIdx] : incoming;
  end

  assign issueOp     = outSel.op;
  assign issueDstTag = outSel.dst;
  assign issueSrcA   = outSel.a.val;
  assign issueSrcB   = outSel.b.val;

endmodule

// File: rtl/tagwait_ctl.sv
module tagwait_ctl
  import tagwait_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  dispValid,
  input  logic                  issueReady,
  input  logic [RS_ENTRIES-1:0] entryRdy,
  input  logic                  dispOperandsOk,
  output logic                  dispReady,
  output logic                  issueValid,
  output ctlStrobe_t            strobe,
  output logic [RS_ENTRIES-1:0] validVec,
  output logic [RS_ENTRIES-1:0] grantVec
);

  // olderThan[j][i] set means entry j was dispatched before entry i.
  logic [RS_ENTRIES-1:0][RS_ENTRIES-1:0] olderThan;
  logic [RS_ENTRIES-1:0] readyVec;
  logic                  anyReady;
  logic [IDX_W-1:0]      grantIdx;
  logic                  hasFree;
  logic [IDX_W-1:0]      freeIdx;
  logic                  bypassTake;
  logic                  doDequeue;
  logic                  doWrite;

  assign readyVec = validVec & entryRdy;
  assign anyReady = |readyVec;

  always_comb begin
    for (int i = 0; i < RS_ENTRIES; i++) begin
      logic blocked;
      blocked = 1'b0;
      for (int j = 0; j < RS_ENTRIES; j++) begin
        if ((j != i) && readyVec[j] && olderThan[j][i]) blocked = 1'b1;
      end
      grantVec[i] = readyVec[i] & ~blocked;
    end
  end

  always_comb begin
    grantIdx = '0;
    for (int i = 0; i < RS_ENTRIES; i++) begin
      if (grantVec[i]) grantIdx = grantIdx | IDX_W'(i);
    end
  end

  always_comb begin
    hasFree = ~(&validVec);
    freeIdx = '0;
    for (int i = RS_ENTRIES - 1; i >= 0; i--) begin
      if (!validVec[i]) freeIdx = IDX_W'(i);
    end
  end

  assign bypassTake = dispValid && dispOperandsOk && !anyReady && issueReady;
  assign issueValid = anyReady || (dispValid && dispOperandsOk);
  assign dispReady  = hasFree || (dispOperandsOk && !anyReady && issueReady);
  assign doWrite    = dispValid && dispReady && !bypassTake;
  assign doDequeue  = anyReady && issueReady;

  always_comb begin
    strobe.writeEn  = doWrite;
    strobe.writeIdx = freeIdx;
    strobe.issueBuf = anyReady;
    strobe.issueIdx = grantIdx;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      validVec <= '0;
    end else begin
      for (int i = 0; i < RS_ENTRIES; i++) begin
        if (doDequeue && grantVec[i]) validVec[i] <= 1'b0;
        else if (doWrite && (freeIdx == IDX_W'(i))) validVec[i] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      olderThan <= '0;
    end else if (doWrite) begin
      for (int j = 0; j < RS_ENTRIES; j++) begin
        olderThan[j][freeIdx] <= 1'b1;
        olderThan[freeIdx][j] <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/tagwait_station.sv
module tagwait_station
  import tagwait_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              dispValid,
  output logic              dispReady,
  input  logic [OP_W-1:0]   dispOp,
  input  logic [TAG_W-1:0]  dispDstTag,
  input  logic              dispSrcARdy,
  input  logic [TAG_W-1:0]  dispSrcATag,
  input  logic [DATA_W-1:0] dispSrcAVal,
  input  logic              dispSrcBRdy,
  input  logic [TAG_W-1:0]  dispSrcBTag,
  input  logic [DATA_W-1:0] dispSrcBVal,
  input  logic              bcastValid,
  input  logic [TAG_W-1:0]  bcastTag,
  input  logic [DATA_W-1:0] bcastVal,
  output logic              issueValid,
  input  logic              issueReady,
  output logic [OP_W-1:0]   issueOp,
  output logic [TAG_W-1:0]  issueDstTag,
  output logic [DATA_W-1:0] issueSrcA,
  output logic [DATA_W-1:0] issueSrcB
);

  ctlStrobe_t            strobe;
  logic [RS_ENTRIES-1:0] entryRdy;
  logic [RS_ENTRIES-1:0] validVec;
  logic [RS_ENTRIES-1:0] grantVec;
  logic                  dispOperandsOk;

  tagwait_ctl u_ctl (
    .clk           (clk),
    .rst           (rst),
    .dispValid     (dispValid),
    .issueReady    (issueReady),
    .entryRdy      (entryRdy),
    .dispOperandsOk(dispOperandsOk),
    .dispReady     (dispReady),
    .issueValid    (issueValid),
    .strobe        (strobe),
    .validVec      (validVec),
    .grantVec      (grantVec)
  );

  tagwait_dp u_dp (
    .clk           (clk),
    .strobe        (strobe),
    .dispOp        (dispOp),
    .dispDstTag    (dispDstTag),
    .dispSrcARdy   (dispSrcARdy),
    .dispSrcATag   (dispSrcATag),
    .dispSrcAVal   (dispSrcAVal),
    .dispSrcBRdy   (dispSrcBRdy),
    .dispSrcBTag   (dispSrcBTag),
    .dispSrcBVal   (dispSrcBVal),
    .bcastValid    (bcastValid),
    .bcastTag      (bcastTag),
    .bcastVal      (bcastVal),
    .entryRdy      (entryRdy),
    .dispOperandsOk(dispOperandsOk),
    .issueOp       (issueOp),
    .issueDstTag   (issueDstTag),
    .issueSrcA     (issueSrcA),
    .issueSrcB     (issueSrcB)
  );

endmodule

// File: rtl/tagwait_station_chk.sv
module tagwait_station_chk
  import tagwait_pkg::*;
(
  input logic                  clk,
  input logic                  rst,
  input logic [RS_ENTRIES-1:0] validVec,
  input logic [RS_ENTRIES-1:0] grantVec,
  input logic [RS_ENTRIES-1:0] entryRdy,
  input ctlStrobe_t            strobe,
  input logic                  dispValid,
  input logic                  dispReady,
  input logic                  issueValid,
  input logic                  issueReady
);

  // R7: one entry at most wins the issue port
  p_single_grant_r7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grantVec));

  // R8: a write lands only in an empty slot
  p_write_empty_slot_r8: assert property (@(posedge clk) disable iff (rst)
    strobe.writeEn |-> !validVec[strobe.writeIdx]);

  // R8: full station with a blocked port refuses dispatch
  p_full_stall_r8: assert property (@(posedge clk) disable iff (rst)
    ((&validVec) && !issueReady) |-> !dispReady);

  // R2: a direct dispatch consumes no entry
  p_bypass_no_slot_r2: assert property (@(posedge clk) disable iff (rst)
    (dispValid && dispReady && issueValid && issueReady && (grantVec == '0)) |-> !strobe.writeEn);

  for (genvar gi = 0; gi < RS_ENTRIES; gi++) begin : g_chk
    // R5: granted entry is valid with both sources present
    p_grant_ready_r5: assert property (@(posedge clk) disable iff (rst)
      grantVec[gi] |-> (validVec[gi] && entryRdy[gi]));

    // R3: a waiting entry never wins the port
    p_waiting_held_r3: assert property (@(posedge clk) disable iff (rst)
      (validVec[gi] && !entryRdy[gi]) |-> !grantVec[gi]);

    // R9: the issued slot is free after the edge
    p_slot_freed_r9: assert property (@(posedge clk) disable iff (rst)
      (grantVec[gi] && issueReady) |=> !validVec[gi]);
  end

endmodule

bind tagwait_station tagwait_station_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .validVec  (validVec),
  .grantVec  (grantVec),
  .entryRdy  (entryRdy),
  .strobe    (strobe),
  .dispValid (dispValid),
  .dispReady (dispReady),
  .issueValid(issueValid),
  .issueReady(issueReady)
);

// File: tb/tagwait_station_test.sv
module tagwait_station_test;
  import tagwait_pkg::*;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic              rst;
  logic              dispValid, dispReady;
  logic [OP_W-1:0]   dispOp;
  logic [TAG_W-1:0]  dispDstTag;
  logic              dispSrcARdy, dispSrcBRdy;
  logic [TAG_W-1:0]  dispSrcATag, dispSrcBTag;
  logic [DATA_W-1:0] dispSrcAVal, dispSrcBVal;
  logic              bcastValid;
  logic [TAG_W-1:0]  bcastTag;
  logic [DATA_W-1:0] bcastVal;
  logic              issueValid, issueReady;
  logic [OP_W-1:0]   issueOp;
  logic [TAG_W-1:0]  issueDstTag;
  logic [DATA_W-1:0] issueSrcA, issueSrcB;

  tagwait_station uut (.*);

  typedef struct packed {
    logic [OP_W-1:0]   op;
    logic [TAG_W-1:0]  dst;
    logic [DATA_W-1:0] a;
    logic [DATA_W-1:0] b;
  } expItem_t;

  expItem_t expQ[$];
  string    expReq[$];
  int nChecks = 0;
  int nFail   = 0;
  bit done    = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic expectIssue(input int op, input int dst, input logic [DATA_W-1:0] a,
                             input logic [DATA_W-1:0] b, input string req);
    expItem_t it;
    it.op  = OP_W'(op);
    it.dst = TAG_W'(dst);
    it.a   = a;
    it.b   = b;
    expQ.push_back(it);
    expReq.push_back(req);
  endtask

  // Monitor: sample just before each rising edge, where a handshake completes.
  initial begin
    forever begin
      @(negedge clk);
      #4;
      if (!rst && issueValid && issueReady) begin
        expItem_t got;
        got = {issueOp, issueDstTag, issueSrcA, issueSrcB};
        if (expQ.size() == 0) begin
          check(1'b0, "R7", "unexpected issue", 128'(got), 128'(0));
        end else begin
          expItem_t e;
          string r;
          e = expQ.pop_front();
          r = expReq.pop_front();
          check(got == e, r, "issued item", 128'(got), 128'(e));
        end
      end
    end
  end

  task automatic drive(input int op, input int dst,
                       input bit ar, input int at, input logic [DATA_W-1:0] av,
                       input bit br, input int bt, input logic [DATA_W-1:0] bv);
    dispValid   = 1'b1;
    dispOp      = OP_W'(op);
    dispDstTag  = TAG_W'(dst);
    dispSrcARdy = ar;
    dispSrcATag = TAG_W'(at);
    dispSrcAVal = av;
    dispSrcBRdy = br;
    dispSrcBTag = TAG_W'(bt);
    dispSrcBVal = bv;
  endtask

  task automatic noDisp();
    dispValid = 1'b0;
  endtask

  task automatic bcast(input bit v, input int tag, input logic [DATA_W-1:0] val);
    bcastValid = v;
    bcastTag   = TAG_W'(tag);
    bcastVal   = val;
  endtask

  task automatic settle();
    #4;
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finishRun();
    end
  end

  initial begin
    rst = 1'b1;
    issueReady = 1'b0;
    noDisp();
    drive(0, 0, 0, 0, '0, 0, 0, '0);
    dispValid = 1'b0;
    bcast(0, 0, '0);
    repeat (3) step();
    rst = 1'b0;
    settle();
    check(issueValid == 1'b0, "R1", "issueValid after reset", 128'(issueValid), 128'(0));
    check(dispReady == 1'b1, "R1", "dispReady after reset", 128'(dispReady), 128'(1));
    step();

    // R2: direct issue of an all-ready instruction
    issueReady = 1'b1;
    drive(1, 1, 1, 0, 32'hA1, 1, 0, 32'hB1);
    expectIssue(1, 1, 32'hA1, 32'hB1, "R2");
    settle();
    check(issueValid == 1'b1, "R2", "direct issue valid", 128'(issueValid), 128'(1));
    step();
    noDisp();
    settle();
    check(issueValid == 1'b0, "R2", "no entry left by direct issue", 128'(issueValid), 128'(0));
    step();

    // R3, R4, R5: waiting source and tag capture
    drive(2, 2, 0, 3, '0, 1, 0, 32'hB2);
    settle();
    check(issueValid == 1'b0, "R3", "waiting dispatch not offered", 128'(issueValid), 128'(0));
    step();
    noDisp();
    bcast(1, 4, 32'hDEAD);
    step();
    bcast(0, 0, '0);
    settle();
    check(issueValid == 1'b0, "R4", "other tag ignored", 128'(issueValid), 128'(0));
    step();
    bcast(0, 3, 32'hBEEF);
    step();
    bcast(0, 0, '0);
    settle();
    check(issueValid == 1'b0, "R4", "presence low ignored", 128'(issueValid), 128'(0));
    step();
    bcast(1, 3, 32'h33);
    expectIssue(2, 2, 32'h33, 32'hB2, "R5");
    settle();
    check(issueValid == 1'b0, "R5", "not offered in capture cycle", 128'(issueValid), 128'(0));
    step();
    bcast(0, 0, '0);
    settle();
    check(issueValid == 1'b1, "R5", "offered after capture", 128'(issueValid), 128'(1));
    step();
    settle();
    check(issueValid == 1'b0, "R5", "drained after issue", 128'(issueValid), 128'(0));
    step();

    // R7, R11: oldest first with the port blocked meanwhile
    issueReady = 1'b0;
    drive(3, 10, 0, 5, '0, 1, 0, 32'h3B);
    step();
    drive(4, 11, 1, 0, 32'h4A, 0, 6, '0);
    step();
    drive(5, 12, 0, 5, '0, 1, 0, 32'h5B);
    step();
    noDisp();
    bcast(1, 6, 32'h66);
    step();
    bcast(1, 5, 32'h55);
    step();
    bcast(0, 0, '0);
    settle();
    check(issueValid == 1'b1, "R11", "ready entries offered while blocked", 128'(issueValid), 128'(1));
    step();
    step();
    settle();
    check(issueValid == 1'b1, "R11", "entries retained while blocked", 128'(issueValid), 128'(1));
    expectIssue(3, 10, 32'h55, 32'h3B, "R7");
    expectIssue(4, 11, 32'h4A, 32'h66, "R7");
    expectIssue(5, 12, 32'h55, 32'h5B, "R7");
    step();
    issueReady = 1'b1;
    repeat (3) step();
    settle();
    check(issueValid == 1'b0, "R7", "all three issued", 128'(issueValid), 128'(0));
    step();

    // R6: same-cycle broadcast on dispatch
    drive(6, 13, 0, 7, '0, 1, 0, 32'h11);
    bcast(1, 7, 32'h77);
    expectIssue(6, 13, 32'h77, 32'h11, "R6");
    settle();
    check(issueValid == 1'b1, "R6", "same-cycle operand allows direct issue", 128'(issueValid), 128'(1));
    step();
    drive(7, 14, 0, 8, '0, 0, 9, '0);
    bcast(1, 8, 32'h88);
    step();
    noDisp();
    bcast(0, 0, '0);
    settle();
    check(issueValid == 1'b0, "R6", "still waits on other source", 128'(issueValid), 128'(0));
    step();
    bcast(1, 9, 32'h99);
    expectIssue(7, 14, 32'h88, 32'h99, "R6");
    step();
    bcast(0, 0, '0);
    step();
    step();

    // R8, R9: fill, stall, bypass while full, free and refill
    issueReady = 1'b0;
    for (int k = 0; k < RS_ENTRIES; k++) begin
      drive(8 + k, 16 + k, 0, 16 + k, '0, 1, 0, DATA_W'(k));
      settle();
      check(dispReady == 1'b1, "R8", "fill accepted", 128'(dispReady), 128'(1));
      step();
    end
    drive(30, 30, 0, 30, '0, 1, 0, 32'h1);
    settle();
    check(dispReady == 1'b0, "R8", "full stalls waiting dispatch", 128'(dispReady), 128'(0));
    step();
    drive(31, 31, 1, 0, 32'hC1, 1, 0, 32'hC2);
    settle();
    check(dispReady == 1'b0, "R8", "full stalls when port blocked", 128'(dispReady), 128'(0));
    step();
    issueReady = 1'b1;
    expectIssue(31, 31, 32'hC1, 32'hC2, "R2");
    settle();
    check(dispReady == 1'b1, "R2", "direct issue accepted while full", 128'(dispReady), 128'(1));
    step();
    noDisp();
    bcast(1, 16, 32'h100);
    expectIssue(8, 16, 32'h100, 32'h0, "R9");
    step();
    bcast(0, 0, '0);
    step();
    drive(40, 30, 0, 31, '0, 1, 0, 32'h40);
    settle();
    check(dispReady == 1'b1, "R9", "freed slot reused", 128'(dispReady), 128'(1));
    step();
    noDisp();
    for (int k = 1; k < RS_ENTRIES; k++) begin
      bcast(1, 16 + k, DATA_W'(32'h100 + k));
      expectIssue(8 + k, 16 + k, DATA_W'(32'h100 + k), DATA_W'(k), "R9");
      step();
    end
    bcast(1, 31, 32'h31);
    expectIssue(40, 30, 32'h31, 32'h40, "R9");
    step();
    bcast(0, 0, '0);
    step();
    step();
    settle();
    check(issueValid == 1'b0, "R9", "station drained", 128'(issueValid), 128'(0));
    step();

    // R10: held ready entry beats a direct dispatch
    issueReady = 1'b0;
    drive(50, 2, 0, 20, '0, 1, 0, 32'h5);
    step();
    noDisp();
    bcast(1, 20, 32'hEE);
    step();
    bcast(0, 0, '0);
    expectIssue(50, 2, 32'hEE, 32'h5, "R10");
    expectIssue(51, 3, 32'hD1, 32'hD2, "R10");
    issueReady = 1'b1;
    drive(51, 3, 1, 0, 32'hD1, 1, 0, 32'hD2);
    settle();
    check(dispReady == 1'b1, "R10", "dispatch stored behind held entry", 128'(dispReady), 128'(1));
    step();
    noDisp();
    step();
    repeat (3) step();

    check(expQ.size() == 0, "R7", "all expected items issued", 128'(expQ.size()), 128'(0));
    done = 1'b1;
    finishRun();
  end

endmodule